// File: doc/BRIEF.md
# Multiline Receive Silo with Alarm

This block is the receive half of an eight-line asynchronous terminal multiplexer as it appears on a 16-bit register bus. Each line presents received characters, or a break condition, as a one-cycle strobe. Each line that software has enabled captures its character into a one-entry holding stage. A fixed-priority drain then moves the held characters, one per cycle, into a shared first-in first-out silo. Each silo entry is tagged with the number of the line it came from.

Software reads the receive buffer word to pop the oldest entry. It polls a control/status word for the done and alarm flags, or waits for the receive interrupt request. Interrupts follow one of two policies. In the first, the request is raised whenever characters are pending. In the second, the request is raised once when the backlog reaches the alarm level. The alarm is armed again only after a read finds the silo empty. A single control bit selects the policy.

Bus address 0 is the control/status word for both reads and writes. At address 1, a read returns the receive buffer and a write sets the line parameters.

Top module: `mux_rx_silo`

## Requirements
- R1: A receive buffer word carries the character in bits 7:0, the line number in bits 10:8, a framing-error flag in bit 13 and a valid flag in bit 15, with all other bits zero. A break is stored with bits 13 and 15 set and a zero character.
- R2: Entries leave the silo in arrival order. Characters strobed on several lines in the same cycle enter the silo in ascending line order.
- R3: With scan enable on, a receive buffer read of an empty silo returns 0x0000.
- R4: A line parameter write selects a line with bits 2:0 and sets that line's receive enable from bit 12. A strobe on a line whose receive enable is clear adds nothing to the silo.
- R5: Control/status bits 5 (scan enable), 6 (receive interrupt enable) and 12 (alarm enable) read back as written. Bit 7 (receive done) reads 1 exactly when scan enable is on and the silo holds at least one entry.
- R6: While the alarm is armed and scan enable is on, the alarm status (control/status bit 13) sets once the silo holds 16 or more entries. Setting the alarm status disarms the alarm.
- R7: Every receive buffer read clears the alarm status. The alarm is re-armed only by a read, with scan enable on, that finds the silo empty.
- R8: `rx_irq` equals receive interrupt enable AND (alarm status if alarm enable is 1, otherwise receive done).
- R9: With scan enable off, a receive buffer read returns 0x0000 and removes nothing. Writing scan enable as 0 clears the alarm status.
- R10: A control/status write with bit 4 set empties the silo, clears every receive enable and the alarm status, and re-arms the alarm. The scan enable, receive interrupt enable and alarm enable bits take their values from the same write.
- R11: The silo holds 64 entries. A character drained into a full silo is discarded.
- R12: After reset the control/status word reads 0x0000, `rx_irq` is low and every receive enable is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_stb | input | 8 | Per-line strobe: a character or break has arrived |
| rx_brk | input | 8 | Per-line flag qualifying the strobe as a break |
| rx_chr | input | 8x8 | Per-line received character |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 1 | Register select: 0 control/status, 1 receive buffer / line parameters |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered on the read edge |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
A strobe is captured at the first rising edge and reaches the silo at the second edge. A burst of n simultaneous strobes is therefore fully drained after n+1 edges. The alarm status follows one edge after the count it depends on. A register read returns its data on the edge that samples the strobe, and receive done and `rx_irq` follow the registered state with no added delay. The bench drives every operation on a falling edge and waits at least one more edge than the longest of these paths (line count plus three after a strobe, two after a bus access). Only then does it read the status word and sample the interrupt pin against its model.

// File: rtl/mux_rx_pkg.sv
package mux_rx_pkg;

    // control/status word bit positions
    localparam int CS_CLEAR  = 4;
    localparam int CS_SCAN   = 5;
    localparam int CS_RXIE   = 6;
    localparam int CS_DONE   = 7;
    localparam int CS_ALM_EN = 12;
    localparam int CS_ALM    = 13;

    // receive buffer word bit positions
    localparam int RB_FERR   = 13;
    localparam int RB_VALID  = 15;

    // line parameter word
    localparam int LP_ENABLE = 12;
    localparam int LINE_W    = 3;

    typedef struct packed {
        logic              brk;
        logic [LINE_W-1:0] line;
        logic [7:0]        chr;
    } rx_entry_t;

    localparam int ENTRY_W = $bits(rx_entry_t);

    function automatic logic [15:0] pack_rbuf(rx_entry_t e);
        logic [15:0] w;
        w = '0;
        w[7:0]             = e.chr;
        w[8 +: LINE_W]     = e.line;
        w[RB_FERR]         = e.brk;
        w[RB_VALID]        = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/rx_line_hold.sv
module rx_line_hold
    import mux_rx_pkg::*;
#(
    parameter int LINE_ID = 0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stb,
    input  logic      brk,
    input  logic [7:0] chr,
    input  logic      enable,
    input  logic      clr,
    input  logic      take,
    output logic      full,
    output rx_entry_t ent
);

    typedef struct packed {
        logic      full;
        rx_entry_t ent;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) st_d.full = 1'b0;
        if (stb && enable) begin
            st_d.full     = 1'b1;
            st_d.ent.brk  = brk;
            st_d.ent.chr  = brk ? 8'h00 : chr;
            st_d.ent.line = LINE_W'(LINE_ID);
        end
        if (clr) st_d.full = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full = st_q.full;
    assign ent  = st_q.ent;

    // R2
    grant_when_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> st_q.full);

endmodule

// File: rtl/rx_silo_fifo.sv
module rx_silo_fifo #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 12,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic             empty
);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] cnt;
    } ptr_t;

    ptr_t st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic             do_push, do_pop, is_full;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        is_full = (st_q.cnt == CNT_W'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        do_push = push && !is_full;
        st_d    = st_q;
        if (do_push) st_d.wptr = bump(st_q.wptr);
        if (do_pop)  st_d.rptr = bump(st_q.rptr);
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
        if (flush) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem_q[st_q.wptr] <= wdata;
    end

    assign head  = mem_q[st_q.rptr];
    assign count = st_q.cnt;
    assign empty = (st_q.cnt == '0);

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R11
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !flush && count == CNT_W'(DEPTH)) |=> count == CNT_W'(DEPTH));

    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/mux_rx_silo.sv
module mux_rx_silo
    import mux_rx_pkg::*;
#(
    parameter int NLINES      = 8,
    parameter int SILO_DEPTH  = 64,
    parameter int ALARM_LEVEL = 16,
    localparam int CNT_W      = $clog2(SILO_DEPTH + 1),
    localparam int SEL_W      = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NLINES-1:0]      rx_stb,
    input  logic [NLINES-1:0]      rx_brk,
    input  logic [NLINES-1:0][7:0] rx_chr,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic                   bus_addr,
    input  logic [15:0]            bus_wdata,
    output logic [15:0]            bus_rdata,
    output logic                   rx_irq
);

    typedef struct packed {
        logic              scan;
        logic              rxie;
        logic              alm_en;
        logic              alm;
        logic              armed;
        logic [NLINES-1:0] line_en;
        logic [15:0]       rdata;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [NLINES-1:0] hold_full, take;
    rx_entry_t         hold_ent [NLINES];
    rx_entry_t         push_ent, head_ent;
    logic              push, pop, flush, silo_empty;
    logic [CNT_W-1:0]  silo_cnt;
    logic              rd_rbuf, rd_csr, wr_csr, wr_lpr, done;
    logic [SEL_W-1:0]  sel;
    logic [15:0]       csr_img;

    // per-line capture stages
    for (genvar g = 0; g < NLINES; g++) begin : g_line
        rx_line_hold #(.LINE_ID(g)) u_hold (
            .clk    (clk),
            .rst_n  (rst_n),
            .stb    (rx_stb[g]),
            .brk    (rx_brk[g]),
            .chr    (rx_chr[g]),
            .enable (st_q.line_en[g]),
            .clr    (flush),
            .take   (take[g]),
            .full   (hold_full[g]),
            .ent    (hold_ent[g])
        );
    end

    // fixed-priority drain: lowest line number first
    always_comb begin
        sel  = '0;
        take = '0;
        for (int i = NLINES - 1; i >= 0; i--) begin
            if (hold_full[i]) sel = SEL_W'(i);
        end
        push = |hold_full;
        if (push) take[sel] = 1'b1;
        push_ent = hold_ent[sel];
    end

    rx_silo_fifo #(
        .DEPTH (SILO_DEPTH),
        .WIDTH (ENTRY_W)
    ) u_silo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .flush (flush),
        .wdata (push_ent),
        .head  (head_ent),
        .count (silo_cnt),
        .empty (silo_empty)
    );

    always_comb begin
        rd_rbuf = bus_rd && bus_addr;
        rd_csr  = bus_rd && !bus_addr;
        wr_csr  = bus_wr && !bus_addr;
        wr_lpr  = bus_wr && bus_addr;
        flush   = wr_csr && bus_wdata[CS_CLEAR];
        pop     = rd_rbuf && st_q.scan && !silo_empty;
        done    = st_q.scan && !silo_empty;

        csr_img            = '0;
        csr_img[CS_SCAN]   = st_q.scan;
        csr_img[CS_RXIE]   = st_q.rxie;
        csr_img[CS_DONE]   = done;
        csr_img[CS_ALM_EN] = st_q.alm_en;
        csr_img[CS_ALM]    = st_q.alm;

        st_d = st_q;

        // alarm detection on the registered backlog
        if (st_q.armed && st_q.scan && silo_cnt >= CNT_W'(ALARM_LEVEL)) begin
            st_d.alm   = 1'b1;
            st_d.armed = 1'b0;
        end

        if (rd_csr) st_d.rdata = csr_img;
        if (rd_rbuf) begin
            st_d.alm = 1'b0;
            if (!st_q.scan)      st_d.rdata = '0;
            else if (silo_empty) begin
                st_d.rdata = '0;
                st_d.armed = 1'b1;
            end else begin
                st_d.rdata = pack_rbuf(head_ent);
            end
        end

        if (wr_lpr) begin
            for (int i = 0; i < NLINES; i++) begin
                if (bus_wdata[LINE_W-1:0] == LINE_W'(i))
                    st_d.line_en[i] = bus_wdata[LP_ENABLE];
            end
        end

        if (wr_csr) begin
            if (flush) begin
                st_d.line_en = '0;
                st_d.alm     = 1'b0;
                st_d.armed   = 1'b1;
            end
            st_d.scan   = bus_wdata[CS_SCAN];
            st_d.rxie   = bus_wdata[CS_RXIE];
            st_d.alm_en = bus_wdata[CS_ALM_EN];
            if (!bus_wdata[CS_SCAN]) st_d.alm = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.armed <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign rx_irq    = st_q.rxie && (st_q.alm_en ? st_q.alm : done);

    // R6
    alarm_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.alm) |-> $past(silo_cnt) >= CNT_W'(ALARM_LEVEL));

    // R7
    read_clears_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rbuf |=> !st_q.alm);

    // R9
    idle_scan_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rbuf && !st_q.scan && !flush) |=> silo_cnt >= $past(silo_cnt));

    // R10
    clear_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.line_en == '0 && st_q.armed));

endmodule

// File: tb/mux_rx_silo_bench.sv
`timescale 1ns/1ps
module mux_rx_silo_bench;

    localparam int NL = 8;
    localparam int DEPTH = 64;
    localparam int ALM = 16;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NL-1:0]       rx_stb = '0;
    logic [NL-1:0]       rx_brk = '0;
    logic [NL-1:0][7:0]  rx_chr = '0;
    logic                bus_wr = 1'b0;
    logic                bus_rd = 1'b0;
    logic                bus_addr = 1'b0;
    logic [15:0]         bus_wdata = '0;
    logic [15:0]         bus_rdata;
    logic                rx_irq;

    mux_rx_silo u_mux_rx_silo (
        .clk(clk), .rst_n(rst_n), .rx_stb(rx_stb), .rx_brk(rx_brk), .rx_chr(rx_chr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rx_irq(rx_irq)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // reference model
    logic [15:0] m_q[$];
    logic [NL-1:0] m_en = '0;
    bit m_scan = 0, m_rxie = 0, m_alm_en = 0, m_alm = 0, m_armed = 1;

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic void m_settle();
        if (m_armed && m_scan && m_q.size() >= ALM) begin
            m_alm = 1;
            m_armed = 0;
        end
    endfunction

    function automatic logic [15:0] m_csr();
        logic [15:0] w = '0;
        w[5] = m_scan; w[6] = m_rxie; w[7] = m_scan && (m_q.size() > 0);
        w[12] = m_alm_en; w[13] = m_alm;
        return w;
    endfunction

    task automatic bus_write(input logic a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic bus_read(input logic a, output logic [15:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
        repeat (2) @(negedge clk);
    endtask

    // R5 R6 R8: status word and interrupt pin against the model
    task automatic check_status(input string tag);
        logic [15:0] v, e;
        logic irq_e;
        bus_read(1'b0, v);
        e = m_csr();
        check(v == e, {tag, " status"}, v, e);
        irq_e = m_rxie && (m_alm_en ? m_alm : e[7]);
        check(rx_irq == irq_e, {tag, " irq R8"}, 16'(rx_irq), 16'(irq_e));
    endtask

    task automatic strobe(input logic [NL-1:0] mask, input logic [NL-1:0] brk,
                          input logic [NL-1:0][7:0] chr);
        @(negedge clk);
        rx_stb = mask; rx_brk = brk; rx_chr = chr;
        @(negedge clk);
        rx_stb = '0; rx_brk = '0;
        repeat (NL + 3) @(negedge clk);
        for (int i = 0; i < NL; i++) begin
            if (mask[i] && m_en[i] && m_q.size() < DEPTH) begin
                logic [15:0] w = '0;
                w[15] = 1'b1; w[10:8] = 3'(i);
                if (brk[i]) w[13] = 1'b1; else w[7:0] = chr[i];
                m_q.push_back(w);
            end
        end
        m_settle();
    endtask

    task automatic read_rbuf(input string tag);
        logic [15:0] v, e;
        bus_read(1'b1, v);
        e = '0;
        if (m_scan) begin
            if (m_q.size() > 0) e = m_q.pop_front();
            else m_armed = 1;
        end
        m_alm = 0;
        m_settle();
        check(v == e, tag, v, e);
    endtask

    task automatic write_lpr(input int line, input bit en, input logic [15:0] junk);
        logic [15:0] d = junk & 16'h6FF8;
        d[2:0] = 3'(line); d[12] = en;
        bus_write(1'b1, d);
        m_en[line] = en;
    endtask

    task automatic write_csr(input bit clr, input bit scan, input bit rxie, input bit alm_en);
        logic [15:0] d = '0;
        d[4] = clr; d[5] = scan; d[6] = rxie; d[12] = alm_en;
        bus_write(1'b0, d);
        if (clr) begin m_q.delete(); m_en = '0; m_alm = 0; m_armed = 1; end
        m_scan = scan; m_rxie = rxie; m_alm_en = alm_en;
        if (!scan) m_alm = 0;
        m_settle();
    endtask

    task automatic push_n(input int n);
        for (int k = 0; k < n; k++) begin
            logic [NL-1:0][7:0] c;
            for (int i = 0; i < NL; i++) c[i] = 8'($urandom);
            strobe(8'h01 << (k % 4), '0, c);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        logic [NL-1:0][7:0] c;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R12: reset state
        check(rx_irq == 1'b0, "R12 irq", 16'(rx_irq), 16'h0);
        check_status("R12");
        read_rbuf("R9 read with scan off");

        // R4 R12: lines disabled after reset
        write_csr(0, 1, 1, 0);
        c = '0; c[0] = 8'h41;
        strobe(8'h01, '0, c);
        read_rbuf("R3 empty read");
        check_status("R4");

        // R1 R2: single, break, and simultaneous arrivals
        for (int i = 0; i < NL; i++) write_lpr(i, 1, 16'($urandom));
        c = '0; c[3] = 8'hC5;
        strobe(8'h08, '0, c);
        check_status("R5 done");
        read_rbuf("R1 char line 3");
        strobe(8'h20, 8'h20, c);
        read_rbuf("R1 break line 5");
        for (int i = 0; i < NL; i++) c[i] = 8'h30 + 8'(i);
        strobe(8'hA6, '0, c);
        for (int k = 0; k < 4; k++) read_rbuf("R2 ascending order");
        read_rbuf("R3 drained");

        // R4: disable one line, strobe it, silo stays empty
        write_lpr(6, 0, 16'hFFFF);
        strobe(8'h40, '0, c);
        read_rbuf("R4 disabled line");

        // R6 R7 R8: alarm mode
        write_csr(0, 1, 1, 1);
        push_n(15);
        check_status("R6 below level");
        push_n(1);
        check_status("R6 at level");
        read_rbuf("R7 pop at alarm");
        check_status("R7 cleared once");
        push_n(3);
        check_status("R7 not rearmed");
        while (m_q.size() > 0) read_rbuf("R2 drain");
        read_rbuf("R7 empty rearm");
        push_n(16);
        check_status("R6 fires again");

        // R9: scan off keeps contents
        write_csr(0, 0, 1, 1);
        read_rbuf("R9 scan off read");
        check_status("R9");
        write_csr(0, 1, 1, 0);
        check_status("R8 done mode");

        // R11: overflow discards
        push_n(60);
        check_status("R11 full");
        read_rbuf("R11 oldest survives");

        // R10: clear
        write_csr(1, 1, 1, 1);
        check_status("R10 cleared");
        strobe(8'hFF, '0, c);
        read_rbuf("R10 enables cleared");

        // random mix
        for (int it = 0; it < 300; it++) begin
            int op = $urandom % 20;
            if (op < 9) begin
                logic [NL-1:0][7:0] rc;
                for (int i = 0; i < NL; i++) rc[i] = 8'($urandom);
                strobe(NL'($urandom), NL'($urandom % 8 == 0 ? $urandom : 0), rc);
            end else if (op < 15) begin
                read_rbuf("R1 random read");
            end else if (op < 18) begin
                write_lpr($urandom % NL, ($urandom % 4) != 0, 16'($urandom));
            end else begin
                write_csr(($urandom % 6) == 0, ($urandom % 5) != 0, $urandom % 2, $urandom % 2);
            end
            if (it % 4 == 0) check_status("R5 random");
        end

        summary();
    end

endmodule